// File: doc/BRIEF.md
# Cyclic-Shift Spreading Chip Generator

This block turns a stream of data symbols into a serial stream of spreading chips. Every codeword is derived at acceptance time from one root chip pattern, which is a parameter. The lower symbol bits choose a cyclic rotation of the root in steps of two chips. The top symbol bit chooses whether every odd-indexed chip is inverted. In long mode a 4-bit symbol gives 16 chips. In short mode a 3-bit symbol gives 8 chips from a second root.

An optional cyclic-prefix slot can be added per symbol. It repeats the symbol's last chip ahead of chip 0. Symbols arrive on a valid/ready handshake. Chips leave one per chip period, marked by a strobe, and the first slot of each symbol carries a start marker. One chip period is `CHIP_DIV` clocks.

A three-state controller sequences the slots. The states are `ST_IDLE`, `ST_PREFIX` and `ST_BODY`. Its transitions are:
- accept-with-prefix: `ST_IDLE` to `ST_PREFIX`.
- accept-without-prefix: `ST_IDLE` to `ST_BODY`.
- prefix-done: `ST_PREFIX` to `ST_BODY`.
- chip-advance: `ST_BODY` to `ST_BODY`.
- chain-with-prefix: from the last body chip to `ST_PREFIX`.
- chain-without-prefix: from the last body chip to `ST_BODY`.
- drain: from the last body chip to `ST_IDLE`.
- reset: any state to `ST_IDLE`.

Top module: `spread_chip_gen`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle, with `sym_ready`=1 and `chip_stb`=`chip_sos`=`chip_out`=0 after the reset edge. Any symbol that was partly sent is dropped and yields no further strobes.
- R2: In long mode (`short_mode`=0 at acceptance), symbol value 0 is sent as the default root 16'h3AFC. The root's MSB is chip 0 and is sent first, so the chip order is 0011101011111100.
- R3: For long-mode values 1 to 7, each step in value rotates the chip pattern right by two chip positions. Value 1 is 0000111010111111 and value 2 is 1100001110101111.
- R4: Long-mode values 8 to 15 equal values 0 to 7 with the odd-indexed chips (chip 1, 3, ..., 15) inverted. Value 8 is 0110111110101001 and value 15 is 1011111010100101.
- R5: In short mode (`short_mode`=1 at acceptance), `sym_in[2:0]` selects an 8-chip codeword from root 8'h45 (01000101) and `sym_in[3]` is ignored. Values 0 to 3 rotate right by two chips per step, and values 4 to 7 invert the odd chips. Value 1 is 01010001 and value 4 is 00010000.
- R6: With `prefix_en`=1 at acceptance, one extra slot carrying a copy of the last chip is sent before chip 0. A long symbol then takes 17 slots and a short symbol 9.
- R7: While a symbol is in flight, `chip_stb` is high for one clock in every `CHIP_DIV` clocks, and `chip_out` holds its value for the whole chip period. The first strobe comes in the clock after acceptance.
- R8: `chip_sos` is high only together with the strobe of a symbol's first slot, which is the prefix slot when one is present.
- R9: `sym_ready` is high in idle and in the final clock of a symbol's last slot, and low otherwise. A symbol is accepted when `sym_valid` and `sym_ready` are both high, so held-valid symbols follow each other with no gap.
- R10: With no symbol in flight, `chip_stb`, `chip_sos` and `chip_out` stay at 0.
- R11: Changes to `sym_in`, `short_mode` or `prefix_en` after acceptance do not affect the symbol being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | Symbol offered |
| sym_ready | output | 1 | Symbol can be taken this clock |
| sym_in | input | 4 | Symbol value (short mode uses bits 2:0) |
| short_mode | input | 1 | 1 selects the 8-chip mode for the offered symbol |
| prefix_en | input | 1 | 1 adds a cyclic-prefix slot to the offered symbol |
| chip_out | output | 1 | Current chip value |
| chip_stb | output | 1 | One-clock strobe at the start of each chip period |
| chip_sos | output | 1 | Start-of-symbol marker, aligned with the first slot's strobe |

## Verification
Single symbols are sent with known chip strings. The plain, rotated and odd-inverted long values separate a wrong rotation direction or step from a wrong inversion parity. The short values with `sym_in[3]` set show whether the mode picks the right root, length and field. Prefixed symbols in both modes show whether the prefix repeats the last chip rather than the first.

A long held-valid stream mixes modes and prefixes while the fields are scrambled after each acceptance. This exposes gaps, lost symbols, and a mid-symbol change of mode or field leaking into a symbol already in flight. A reset in the middle of a symbol shows whether the remainder is discarded.

// File: rtl/spread_pkg.sv
package spread_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PREFIX = 2'd1,
        ST_BODY   = 2'd2
    } gen_state_t;
endpackage

// File: rtl/spread_code_builder.sv
// Builds the codeword for one symbol from a root pattern by rotation and
// odd-chip inversion. Bit k of each output is the chip sent in position k.
module spread_code_builder #(
    parameter int          N_LONG     = 16,
    parameter int          N_SHORT    = 8,
    parameter logic [15:0] ROOT_LONG  = 16'h3AFC,
    parameter logic [7:0]  ROOT_SHORT = 8'h45
) (
    input  logic [$clog2(N_LONG)-1:0] sym,
    input  logic                      short_mode,
    output logic [N_LONG-1:0]         code
);
    localparam int LB_L = $clog2(N_LONG);
    localparam int LB_S = $clog2(N_SHORT);

    logic [LB_L-2:0]     rot_l;
    logic                inv_l;
    logic [LB_S-2:0]     rot_s;
    logic                inv_s;
    logic [N_LONG-1:0]   long_code;
    logic [N_SHORT-1:0]  short_code;

    assign rot_l = sym[LB_L-2:0];
    assign inv_l = sym[LB_L-1];
    assign rot_s = sym[LB_S-2:0];
    assign inv_s = sym[LB_S-1];

    for (genvar k = 0; k < N_LONG; k++) begin : g_long
        always_comb begin
            int sh;
            int src;
            sh  = 2 * int'(rot_l);
            src = (k >= sh) ? (k - sh) : (k + N_LONG - sh);
            long_code[k] = ROOT_LONG[N_LONG-1-src] ^ (inv_l & ((k % 2) == 1));
        end
    end

    for (genvar k = 0; k < N_SHORT; k++) begin : g_short
        always_comb begin
            int sh;
            int src;
            sh  = 2 * int'(rot_s);
            src = (k >= sh) ? (k - sh) : (k + N_SHORT - sh);
            short_code[k] = ROOT_SHORT[N_SHORT-1-src] ^ (inv_s & ((k % 2) == 1));
        end
    end

    always_comb begin
        code = '0;
        if (short_mode)
            code[N_SHORT-1:0] = short_code;
        else
            code = long_code;
    end
endmodule

// File: rtl/spread_chip_pacer.sv
// Divides the clock into chip periods while a symbol is in flight.
module spread_chip_pacer #(
    parameter int CHIP_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick,
    output logic period_end
);
    if (CHIP_DIV == 1) begin : g_direct
        assign tick       = run;
        assign period_end = 1'b1;
    end else begin : g_count
        localparam int CW = $clog2(CHIP_DIV);
        logic [CW-1:0] cnt;

        always_ff @(posedge clk) begin
            if (rst)
                cnt <= '0;
            else if (run)
                cnt <= (cnt == CW'(CHIP_DIV-1)) ? '0 : cnt + 1'b1;
        end

        assign tick       = run && (cnt == '0);
        assign period_end = (cnt == CW'(CHIP_DIV-1));
    end
endmodule

// File: rtl/spread_chip_gen.sv
module spread_chip_gen
    import spread_pkg::*;
#(
    parameter int          N_LONG     = 16,
    parameter int          N_SHORT    = 8,
    parameter logic [15:0] ROOT_LONG  = 16'h3AFC,
    parameter logic [7:0]  ROOT_SHORT = 8'h45,
    parameter int          CHIP_DIV   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_valid,
    output logic       sym_ready,
    input  logic [3:0] sym_in,
    input  logic       short_mode,
    input  logic       prefix_en,
    output logic       chip_out,
    output logic       chip_stb,
    output logic       chip_sos
);
    localparam int IDX_W = $clog2(N_LONG);

    gen_state_t        state, state_nx;
    logic [N_LONG-1:0] code_q, code_new;
    logic [IDX_W-1:0]  idx_q, idx_nx;
    logic              short_q, pre_q;
    logic [IDX_W-1:0]  last_idx;
    logic              tick, period_end, run;
    logic              accept, last_slot;

    spread_code_builder #(
        .N_LONG(N_LONG), .N_SHORT(N_SHORT),
        .ROOT_LONG(ROOT_LONG), .ROOT_SHORT(ROOT_SHORT)
    ) u_build (
        .sym(sym_in[IDX_W-1:0]),
        .short_mode(short_mode),
        .code(code_new)
    );

    assign run = (state != ST_IDLE);

    spread_chip_pacer #(.CHIP_DIV(CHIP_DIV)) u_pace (
        .clk(clk), .rst(rst), .run(run),
        .tick(tick), .period_end(period_end)
    );

    assign last_idx  = short_q ? IDX_W'(N_SHORT-1) : IDX_W'(N_LONG-1);
    assign last_slot = (state == ST_BODY) && (idx_q == last_idx);
    assign accept    = sym_valid && sym_ready;

    // next state and chip index
    always_comb begin
        state_nx = state;
        idx_nx   = idx_q;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_nx = prefix_en ? ST_PREFIX : ST_BODY;
                    idx_nx   = '0;
                end
            end
            ST_PREFIX: begin
                if (period_end) state_nx = ST_BODY;
            end
            ST_BODY: begin
                if (period_end) begin
                    if (last_slot) begin
                        idx_nx = '0;
                        if (accept) state_nx = prefix_en ? ST_PREFIX : ST_BODY;
                        else        state_nx = ST_IDLE;
                    end else begin
                        idx_nx = idx_q + 1'b1;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            idx_q   <= '0;
            code_q  <= '0;
            short_q <= 1'b0;
            pre_q   <= 1'b0;
        end else begin
            state <= state_nx;
            idx_q <= idx_nx;
            if (accept) begin
                code_q  <= code_new;
                short_q <= short_mode;
                pre_q   <= prefix_en;
            end
        end
    end

    // outputs
    always_comb begin
        sym_ready = 1'b0;
        chip_out  = 1'b0;
        chip_stb  = 1'b0;
        chip_sos  = 1'b0;
        unique case (state)
            ST_IDLE: sym_ready = 1'b1;
            ST_PREFIX: begin
                chip_out = code_q[last_idx];
                chip_stb = tick;
                chip_sos = tick;
            end
            ST_BODY: begin
                chip_out  = code_q[idx_q];
                chip_stb  = tick;
                chip_sos  = tick && (idx_q == '0) && !pre_q;
                sym_ready = last_slot && period_end;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spread_chip_gen_chk.sv
module spread_chip_gen_chk #(
    parameter int CHIP_DIV = 2
) (
    input logic clk,
    input logic rst,
    input logic sym_valid,
    input logic sym_ready,
    input logic chip_out,
    input logic chip_stb,
    input logic chip_sos
);
    logic prev_rdy;
    always_ff @(posedge clk) begin
        if (rst) prev_rdy <= 1'b1;
        else     prev_rdy <= sym_ready;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (sym_ready && !chip_stb && !chip_sos));

    assert_sos_on_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        chip_sos |-> chip_stb);

    assert_hold_chip_R7: assert property (@(posedge clk) disable iff (rst)
        (!chip_stb && !prev_rdy) |-> $stable(chip_out));

    if (CHIP_DIV > 1) begin : g_gap
        assert_strobe_spacing_R7: assert property (@(posedge clk) disable iff (rst)
            chip_stb |=> !chip_stb);
    end

    assert_accept_starts_R9: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_ready) |=> (chip_stb && chip_sos));
endmodule

bind spread_chip_gen spread_chip_gen_chk #(.CHIP_DIV(CHIP_DIV)) u_chk (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .chip_out(chip_out), .chip_stb(chip_stb), .chip_sos(chip_sos)
);

// File: tb/spread_chip_gen_test.sv
module spread_chip_gen_test;
    localparam int TB_DIV = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_valid = 1'b0;
    logic [3:0] sym_in = '0;
    logic       short_mode = 1'b0;
    logic       prefix_en = 1'b0;
    logic       sym_ready, chip_out, chip_stb, chip_sos;

    int total = 0;
    int bad = 0;
    bit started = 0;

    always #10 clk = ~clk;   // 50 MHz

    spread_chip_gen #(.CHIP_DIV(TB_DIV)) uut (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_ready(sym_ready),
        .sym_in(sym_in), .short_mode(short_mode), .prefix_en(prefix_en),
        .chip_out(chip_out), .chip_stb(chip_stb), .chip_sos(chip_sos)
    );

    task automatic chk(input bit ok, input string req, input string act, input string exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    // chip from the requirement strings, chip 0 is the leftmost character
    function automatic bit ref_chip(input int n, input int s, input int k);
        string root;
        int r, src;
        bit inv, c;
        root = (n == 16) ? "0011101011111100" : "01000101";
        r    = s % (n / 2);
        inv  = (s >= n / 2);
        src  = ((k - 2 * r) % n + n) % n;
        c    = (root[src] == "1");
        return c ^ (inv && (k % 2 == 1));
    endfunction

    // behavioural reference model
    bit m_busy = 0;
    bit m_first = 0;
    int m_div = 0;
    bit m_q[$];

    function automatic bit m_ready();
        return !m_busy || (m_q.size() == 1 && m_div == TB_DIV - 1);
    endfunction

    always @(posedge clk) begin
        bit acc;
        started = 1;
        if (rst) begin
            m_busy = 0; m_q.delete(); m_div = 0; m_first = 0;
        end else begin
            acc = sym_valid && m_ready();
            if (m_busy) begin
                if (m_div == TB_DIV - 1) begin
                    void'(m_q.pop_front());
                    m_first = 0; m_div = 0;
                    if (m_q.size() == 0) m_busy = 0;
                end else m_div++;
            end
            if (acc) begin
                int n, s;
                n = short_mode ? 8 : 16;
                s = short_mode ? int'(sym_in[2:0]) : int'(sym_in);
                if (prefix_en) m_q.push_back(ref_chip(n, s, n - 1));
                for (int k = 0; k < n; k++) m_q.push_back(ref_chip(n, s, k));
                m_busy = 1; m_div = 0; m_first = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            bit e_stb, e_chip, e_sos, e_rdy;
            e_rdy  = m_ready();
            e_stb  = m_busy && m_div == 0;
            e_chip = m_busy ? m_q[0] : 1'b0;
            e_sos  = e_stb && m_first;
            chk({sym_ready, chip_stb, chip_out, chip_sos} == {e_rdy, e_stb, e_chip, e_sos},
                "R7/R8/R9/R10 model",
                $sformatf("%b%b%b%b", sym_ready, chip_stb, chip_out, chip_sos),
                $sformatf("%b%b%b%b", e_rdy, e_stb, e_chip, e_sos));
        end
    end

    // chip collector
    string got = "";
    int sos_cnt = 0;
    always @(negedge clk) begin
        if (chip_stb) begin
            if (chip_sos) begin got = ""; sos_cnt++; end
            got = {got, chip_out ? "1" : "0"};
        end
    end

    task automatic send(input logic [3:0] s, input bit sh, input bit pe, input bit hold);
        @(negedge clk);
        sym_valid = 1; sym_in = s; short_mode = sh; prefix_en = pe;
        while (!sym_ready) @(negedge clk);
        @(negedge clk);
        if (!hold) sym_valid = 0;
        // R11: scramble the fields once the symbol has been taken
        sym_in = ~s; short_mode = ~sh; prefix_en = ~pe;
    endtask

    task automatic one(input logic [3:0] s, input bit sh, input bit pe,
                       input string exp, input string req);
        send(s, sh, pe, 0);
        while (!sym_ready) @(negedge clk);
        @(negedge clk);
        chk(got == exp, req, got, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk(sym_ready && !chip_stb && !chip_sos && !chip_out, "R1 reset state",
            $sformatf("%b%b%b%b", sym_ready, chip_stb, chip_sos, chip_out), "1000");

        one(4'd0,  0, 0, "0011101011111100", "R2 long value 0");
        one(4'd1,  0, 0, "0000111010111111", "R3 long value 1");
        one(4'd2,  0, 0, "1100001110101111", "R3 long value 2");
        one(4'd8,  0, 0, "0110111110101001", "R4 long value 8");
        one(4'd15, 0, 0, "1011111010100101", "R4 long value 15");
        one(4'd1,  1, 0, "01010001",         "R5 short value 1");
        one(4'hC,  1, 0, "00010000",         "R5 short value 4, bit 3 ignored");
        one(4'd0,  0, 1, "00011101011111100", "R6 long prefix");
        one(4'd1,  1, 1, "101010001",         "R6 short prefix");
        one(4'd7,  0, 1, "01110101111110000", "R6 R11 prefix value 7");

        // R10: idle outputs stay quiet
        repeat (4) begin
            @(negedge clk);
            chk(!chip_stb && !chip_sos && !chip_out && sym_ready, "R10 idle",
                $sformatf("%b%b%b", chip_stb, chip_sos, chip_out), "000");
        end

        // R9: held-valid stream, the model checks every clock for gaps
        begin
            int start_cnt;
            start_cnt = sos_cnt;
            for (int i = 0; i < 24; i++)
                send(4'((i * 7) % 16), (i % 3) == 1, (i % 4) == 2, 1);
            sym_valid = 0;
            while (!sym_ready) @(negedge clk);
            @(negedge clk);
            chk(sos_cnt - start_cnt == 24, "R9 R8 stream symbols",
                $sformatf("%0d", sos_cnt - start_cnt), "24");
        end

        // R1: reset in the middle of a symbol
        send(4'd5, 0, 0, 0);
        repeat (5) @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk(sym_ready && !chip_stb && !chip_sos && !chip_out, "R1 mid-symbol reset",
            $sformatf("%b%b%b%b", sym_ready, chip_stb, chip_sos, chip_out), "1000");
        begin
            int stb_seen;
            stb_seen = 0;
            repeat (20) begin
                @(negedge clk);
                if (chip_stb) stb_seen++;
            end
            chk(stb_seen == 0, "R1 dropped symbol", $sformatf("%0d", stb_seen), "0");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule